// File: doc/BRIEF.md
# Lane-Partitioned SIMD Multiply-Accumulate Array

The block is a group of identical processing lanes. Each lane has its own local memory, built from several banks, and a row of multiply-accumulate elements that work on one fixed-width execution word. One compute instruction is broadcast to all lanes. The instruction names an operation, an element type, two source addresses, a destination address and an accumulate flag. Every lane reads its own operands at those addresses, computes element by element and writes the saturated result back to the same address in its own memory. No lane can reach another lane's data.

The execution word is EU_BYTES bytes wide (64 by default). The element type decides how many elements that word holds: 64 of 8 bits, 32 of 16 bits or 16 of 32 bits. Data moves into and out of the lanes only through a load/store port. That port reaches one word in one lane per cycle, chosen by a lane index and a word index. A compute instruction occupies the array for three cycles, and during that time both the port and further instructions are refused. An instruction that carries a bad address or a reserved type raises a sticky error and writes nothing.

Top module: `simd_lane_array`

## Requirements
- R1: While reset is held, and in the cycle after it is released, busy, err_flag and ls_rvalid are 0.
- R2: A load/store write (ls_en=1, ls_we=1) stores ls_wdata into word ls_word of lane ls_lane only. A read (ls_en=1, ls_we=0) returns that word on ls_rdata, with ls_rvalid=1, in the next cycle.
- R3: An instruction byte address A with its top bit clear and its low log2(EU_BYTES) bits zero selects load/store word A/EU_BYTES. The upper bits of the word index choose the bank and the lower bits choose the offset within that bank.
- R4: One instruction runs in every lane at the same addresses, and each lane works only on its own memory contents.
- R5: With dtype 00 (int8) the word holds 64 signed elements, element i at bits [8i+7:8i]. With op 0 each result is a*b, saturated to the range -128..127.
- R6: With dtype 01 (int16) the word holds 32 signed elements, element i at bits [16i+15:16i], and each result is saturated to 16 bits.
- R7: With dtype 10 (int32) the word holds 16 signed elements, element i at bits [32i+31:32i], and each result is saturated to 32 bits.
- R8: With op 1 each result is a+b instead of a*b.
- R9: With acc=1 the old destination element is added to the product or sum before saturation. With acc=0 the old value has no effect.
- R10: An instruction is accepted when instr_valid=1 and busy=0. busy is then 1 for exactly three cycles, and the result can be read as soon as busy is 0 again.
- R11: While busy=1 the load/store port is ignored: a write does not change memory and a read gives no ls_rvalid.
- R12: If any of the three addresses is misaligned or has its top bit set, or dtype is 11, err_flag becomes 1 in the cycle after acceptance and stays 1 until reset, and no lane writes the destination. A later valid instruction still executes.
- R13: An instruction presented while busy=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_op | input | 1 | 0 multiply, 1 add |
| instr_dtype | input | 2 | 00 int8, 01 int16, 10 int32, 11 reserved |
| instr_acc | input | 1 | Add old destination value |
| instr_src_a | input | 11 | Lane byte address of operand a |
| instr_src_b | input | 11 | Lane byte address of operand b |
| instr_dst | input | 11 | Lane byte address of the result |
| busy | output | 1 | Instruction in flight |
| err_flag | output | 1 | Sticky bad-instruction flag |
| ls_en | input | 1 | Load/store request |
| ls_we | input | 1 | 1 write, 0 read |
| ls_lane | input | 2 | Target lane |
| ls_word | input | 4 | Word index within the lane |
| ls_wdata | input | 512 | Write word |
| ls_rdata | output | 512 | Read word |
| ls_rvalid | output | 1 | ls_rdata valid |

## Verification
The assertions check on every cycle that acceptance raises busy, and that the latched instruction fields do not change while busy is high. They also check that a read requested during busy never produces ls_rvalid, that err_flag never clears, and that a lane never receives a port write and a result write in the same cycle. Only the bench scenarios can show the arithmetic itself. That covers element packing for each type, saturation, the accumulate path, address-to-bank mapping and lane isolation, and the absence of any write after a bad instruction. The bench shows these by comparing memory read back through the port against its own model.

// File: rtl/simd_pkg.sv
// Shared types for the lane array: element type and operation codes.
package simd_pkg;
    typedef enum logic [1:0] {
        DT_I8  = 2'b00,
        DT_I16 = 2'b01,
        DT_I32 = 2'b10,
        DT_RSV = 2'b11
    } dtype_e;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_ADD = 1'b1
    } op_e;

    typedef struct packed {
        op_e    op;
        dtype_e dt;
        logic   acc;
    } ctl_t;
endpackage

// File: rtl/simd_elem.sv
// One signed element of width W.
// Stage 2 registers the product or sum of a and b, together with the optional addend.
// Stage 3 (combinational) adds them and saturates the total to W bits.
// Assumes the inputs hold still in the cycle en_mul is high.
module simd_elem #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_mul,
    input  logic         op_add,
    input  logic         acc_en,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] res_o
);
    localparam int PW = 2 * W;
    localparam int SW = 2 * W + 1;

    logic signed [PW-1:0] raw_q, raw_d;
    logic        [W-1:0]  addend_q;
    logic signed [SW-1:0] sum;
    logic        [W+1:0]  head;

    // Form product or sum at double width so that no bit is lost.
    always_comb begin
        if (op_add)
            raw_d = $signed({{W{a_i[W-1]}}, a_i}) + $signed({{W{b_i[W-1]}}, b_i});
        else
            raw_d = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    end

    // Stage 2 register: raw result and addend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q    <= '0;
            addend_q <= '0;
        end else if (en_mul) begin
            raw_q    <= raw_d;
            addend_q <= acc_en ? c_i : '0;
        end
    end

    // Accumulate and saturate to the element width.
    always_comb begin
        sum  = $signed({raw_q[PW-1], raw_q}) + $signed({{(W+1){addend_q[W-1]}}, addend_q});
        head = sum[SW-1:W-1];
        if ((&head) || !(|head))
            res_o = sum[W-1:0];
        else if (sum[SW-1])
            res_o = {1'b1, {(W-1){1'b0}}};
        else
            res_o = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/simd_lane.sv
// One processing lane: banked private memory, operand registers and the element rows
// for all three element widths.
// The bank comes from the upper bits of the word index and the offset from the lower bits.
// Assumes the caller never raises ls_we_i and wr_en_i in the same cycle, and keeps the
// indices and controls steady while an instruction is in flight.
module simd_lane
    import simd_pkg::*;
#(
    parameter int EU_BYTES = 64,
    parameter int BANKS    = 4,
    parameter int WPB      = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ls_we_i,
    input  logic [$clog2(BANKS*WPB)-1:0]          ls_idx_i,
    input  logic [EU_BYTES*8-1:0]                 ls_wdata_i,
    output logic [EU_BYTES*8-1:0]                 ls_rdata_o,
    input  logic                                  rd_en_i,
    input  logic                                  mul_en_i,
    input  logic                                  wr_en_i,
    input  logic [$clog2(BANKS*WPB)-1:0]          idx_a_i,
    input  logic [$clog2(BANKS*WPB)-1:0]          idx_b_i,
    input  logic [$clog2(BANKS*WPB)-1:0]          idx_d_i,
    input  ctl_t                                  ctl_i
);
    localparam int WB   = EU_BYTES * 8;
    localparam int WI_W = $clog2(BANKS * WPB);
    localparam int OF_W = $clog2(WPB);
    localparam int BK_W = WI_W - OF_W;
    localparam int N8   = EU_BYTES;
    localparam int N16  = EU_BYTES / 2;
    localparam int N32  = EU_BYTES / 4;

    logic [WB-1:0] rd_ls [BANKS];
    logic [WB-1:0] rd_a  [BANKS];
    logic [WB-1:0] rd_b  [BANKS];
    logic [WB-1:0] rd_d  [BANKS];
    logic [WB-1:0] opa_q, opb_q, opc_q;
    logic [WB-1:0] res8, res16, res32, res_word;

    for (genvar bk = 0; bk < BANKS; bk++) begin : g_bank
        logic [WB-1:0] mem [WPB];
        logic          ls_hit, wb_hit;
        assign ls_hit = ls_we_i && (ls_idx_i[WI_W-1:OF_W] == BK_W'(bk));
        assign wb_hit = wr_en_i && (idx_d_i[WI_W-1:OF_W] == BK_W'(bk));

        // Bank write: a port store or a result write-back.
        always_ff @(posedge clk) begin
            if (ls_hit) mem[ls_idx_i[OF_W-1:0]] <= ls_wdata_i;
            if (wb_hit) mem[idx_d_i[OF_W-1:0]] <= res_word;
        end

        assign rd_ls[bk] = mem[ls_idx_i[OF_W-1:0]];
        assign rd_a[bk]  = mem[idx_a_i[OF_W-1:0]];
        assign rd_b[bk]  = mem[idx_b_i[OF_W-1:0]];
        assign rd_d[bk]  = mem[idx_d_i[OF_W-1:0]];
    end

    assign ls_rdata_o = rd_ls[ls_idx_i[WI_W-1:OF_W]];

    // Stage 1: capture both operands and the old destination word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            opc_q <= '0;
        end else if (rd_en_i) begin
            opa_q <= rd_a[idx_a_i[WI_W-1:OF_W]];
            opb_q <= rd_b[idx_b_i[WI_W-1:OF_W]];
            opc_q <= rd_d[idx_d_i[WI_W-1:OF_W]];
        end
    end

    for (genvar i = 0; i < N8; i++) begin : g_e8
        simd_elem #(.W(8)) u_elem (
            .clk(clk), .rst_n(rst_n), .en_mul(mul_en_i), .op_add(ctl_i.op == OP_ADD),
            .acc_en(ctl_i.acc), .a_i(opa_q[i*8 +: 8]), .b_i(opb_q[i*8 +: 8]),
            .c_i(opc_q[i*8 +: 8]), .res_o(res8[i*8 +: 8]));
    end
    for (genvar i = 0; i < N16; i++) begin : g_e16
        simd_elem #(.W(16)) u_elem (
            .clk(clk), .rst_n(rst_n), .en_mul(mul_en_i), .op_add(ctl_i.op == OP_ADD),
            .acc_en(ctl_i.acc), .a_i(opa_q[i*16 +: 16]), .b_i(opb_q[i*16 +: 16]),
            .c_i(opc_q[i*16 +: 16]), .res_o(res16[i*16 +: 16]));
    end
    for (genvar i = 0; i < N32; i++) begin : g_e32
        simd_elem #(.W(32)) u_elem (
            .clk(clk), .rst_n(rst_n), .en_mul(mul_en_i), .op_add(ctl_i.op == OP_ADD),
            .acc_en(ctl_i.acc), .a_i(opa_q[i*32 +: 32]), .b_i(opb_q[i*32 +: 32]),
            .c_i(opc_q[i*32 +: 32]), .res_o(res32[i*32 +: 32]));
    end

    // Pick the result row that matches the element type.
    always_comb begin
        case (ctl_i.dt)
            DT_I16:  res_word = res16;
            DT_I32:  res_word = res32;
            default: res_word = res8;
        endcase
    end

    // The port and the write-back never share a write cycle (R11).
    assert_single_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_we_i && wr_en_i));
endmodule

// File: rtl/simd_lane_array.sv
// Top of the lane array.
// Accepts broadcast instructions, checks the addresses and type, and runs a fixed
// three-stage sequence (read, multiply, write).
// Gates the load/store port with busy and routes the port to one lane at a time.
// Assumes LANES, BANKS, BANK_BYTES and EU_BYTES are powers of two, LANES >= 2 and
// BANK_BYTES >= 2*EU_BYTES.
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int BANKS      = 4,
    parameter int BANK_BYTES = 256,
    parameter int EU_BYTES   = 64,
    localparam int LA_W      = $clog2(BANKS * BANK_BYTES),
    localparam int AW        = LA_W + 1,
    localparam int WS        = $clog2(EU_BYTES),
    localparam int WI_W      = LA_W - WS,
    localparam int LN_W      = $clog2(LANES),
    localparam int WB        = EU_BYTES * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic            instr_op,
    input  logic [1:0]      instr_dtype,
    input  logic            instr_acc,
    input  logic [AW-1:0]   instr_src_a,
    input  logic [AW-1:0]   instr_src_b,
    input  logic [AW-1:0]   instr_dst,
    output logic            busy,
    output logic            err_flag,
    input  logic            ls_en,
    input  logic            ls_we,
    input  logic [LN_W-1:0] ls_lane,
    input  logic [WI_W-1:0] ls_word,
    input  logic [WB-1:0]   ls_wdata,
    output logic [WB-1:0]   ls_rdata,
    output logic            ls_rvalid
);
    localparam int WPB = BANK_BYTES / EU_BYTES;

    logic            s1_q, s2_q, s3_q, supp_q, err_q, rvalid_q;
    logic            accept, bad, ls_rd_ok;
    logic [WI_W-1:0] ia_q, ib_q, id_q;
    ctl_t            ctl_q;
    logic [WB-1:0]   rdata_q;
    logic [WB-1:0]   lane_rd [LANES];

    function automatic logic addr_bad(input logic [AW-1:0] a);
        return a[AW-1] || (a[WS-1:0] != '0);
    endfunction

    assign busy     = s1_q || s2_q || s3_q;
    assign accept   = instr_valid && !busy;
    assign bad      = addr_bad(instr_src_a) || addr_bad(instr_src_b) ||
                      addr_bad(instr_dst) || (dtype_e'(instr_dtype) == DT_RSV);
    assign ls_rd_ok = ls_en && !ls_we && !busy;

    // Instruction latch, stage sequencing and the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
            supp_q <= 1'b0; err_q <= 1'b0;
            ia_q <= '0; ib_q <= '0; id_q <= '0;
            ctl_q <= '{op: OP_MUL, dt: DT_I8, acc: 1'b0};
        end else begin
            s1_q <= accept;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (accept) begin
                ia_q   <= instr_src_a[LA_W-1:WS];
                ib_q   <= instr_src_b[LA_W-1:WS];
                id_q   <= instr_dst[LA_W-1:WS];
                ctl_q  <= '{op: op_e'(instr_op), dt: dtype_e'(instr_dtype), acc: instr_acc};
                supp_q <= bad;
                if (bad) err_q <= 1'b1;
            end
        end
    end

    // Load/store read: register the selected lane's word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= ls_rd_ok;
            if (ls_rd_ok) rdata_q <= lane_rd[ls_lane];
        end
    end

    assign err_flag  = err_q;
    assign ls_rvalid = rvalid_q;
    assign ls_rdata  = rdata_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane #(.EU_BYTES(EU_BYTES), .BANKS(BANKS), .WPB(WPB)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .ls_we_i(ls_en && ls_we && !busy && (ls_lane == LN_W'(i))),
            .ls_idx_i(ls_word), .ls_wdata_i(ls_wdata), .ls_rdata_o(lane_rd[i]),
            .rd_en_i(s1_q), .mul_en_i(s2_q), .wr_en_i(s3_q && !supp_q),
            .idx_a_i(ia_q), .idx_b_i(ib_q), .idx_d_i(id_q), .ctl_i(ctl_q));
    end

    // Acceptance always starts a busy period (R10).
    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // Instructions offered while busy do not disturb the latched one (R13).
    assert_fields_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(id_q) && $stable(ia_q) && $stable(ib_q) && $stable(ctl_q)));
    // A read offered while busy yields no valid data (R11).
    assert_no_read_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ls_rvalid);
    // The error flag never clears outside reset (R12).
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: tb/tb_simd_lane_array.sv
module tb_simd_lane_array;
    localparam int LANES = 4;
    localparam int WORDS = 16;
    localparam int WB    = 512;
    localparam int AW    = 11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, instr_valid, instr_op, instr_acc, busy, err_flag;
    logic [1:0]    instr_dtype;
    logic [AW-1:0] instr_src_a, instr_src_b, instr_dst;
    logic          ls_en, ls_we, ls_rvalid;
    logic [1:0]    ls_lane;
    logic [3:0]    ls_word;
    logic [WB-1:0] ls_wdata, ls_rdata;

    simd_lane_array dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_dtype(instr_dtype), .instr_acc(instr_acc), .instr_src_a(instr_src_a),
        .instr_src_b(instr_src_b), .instr_dst(instr_dst), .busy(busy), .err_flag(err_flag),
        .ls_en(ls_en), .ls_we(ls_we), .ls_lane(ls_lane), .ls_word(ls_word),
        .ls_wdata(ls_wdata), .ls_rdata(ls_rdata), .ls_rvalid(ls_rvalid));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [WB-1:0] model [LANES][WORDS];
    logic [63:0]   rng = 64'h1234_5678_9abc_def1;

    function automatic logic [63:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic logic [WB-1:0] rnd_word();
        logic [WB-1:0] w = '0;
        for (int k = 0; k < 8; k++) w[k*64 +: 64] = next_rng();
        return w;
    endfunction

    function automatic longint elem(logic [WB-1:0] v, int i, int w);
        logic [WB-1:0] t = v >> (i * w);
        longint x = longint'({32'd0, t[31:0]}) & ((64'sd1 <<< w) - 1);
        if (x >= (64'sd1 <<< (w - 1))) x = x - (64'sd1 <<< w);
        return x;
    endfunction

    function automatic logic [WB-1:0] calc(logic op, logic [1:0] dt, logic acc,
                                           logic [WB-1:0] a, logic [WB-1:0] b, logic [WB-1:0] c);
        int w = 8 << dt;
        int n = 64 >> dt;
        longint mx = (64'sd1 <<< (w - 1)) - 1;
        longint mn = -(64'sd1 <<< (w - 1));
        logic [WB-1:0] r = '0;
        for (int i = 0; i < n; i++) begin
            longint s;
            logic [WB-1:0] t = '0;
            s = op ? elem(a, i, w) + elem(b, i, w) : elem(a, i, w) * elem(b, i, w);
            if (acc) s = s + elem(c, i, w);
            if (s > mx) s = mx;
            if (s < mn) s = mn;
            t[63:0] = s & ((64'sd1 <<< w) - 1);
            r = r | (t << (i * w));
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [WB-1:0] act, logic [WB-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic ls_write(int lane, int word, logic [WB-1:0] data);
        @(negedge clk);
        ls_en = 1; ls_we = 1; ls_lane = 2'(lane); ls_word = 4'(word); ls_wdata = data;
        @(negedge clk);
        ls_en = 0; ls_we = 0;
        model[lane][word] = data;
    endtask

    task automatic verify(string tag, int lane, int word);
        @(negedge clk);
        ls_en = 1; ls_we = 0; ls_lane = 2'(lane); ls_word = 4'(word);
        @(negedge clk);
        chk1({tag, " rvalid"}, ls_rvalid, 1'b1);
        chk(tag, ls_rdata, model[lane][word]);
        ls_en = 0;
    endtask

    function automatic bit is_bad(logic [1:0] dt, logic [AW-1:0] a, logic [AW-1:0] b,
                                  logic [AW-1:0] d);
        return dt == 2'b11 || a[10] || b[10] || d[10] ||
               a[5:0] != 0 || b[5:0] != 0 || d[5:0] != 0;
    endfunction

    function automatic void apply_model(logic op, logic [1:0] dt, logic acc,
                                        logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] d);
        if (!is_bad(dt, a, b, d))
            for (int l = 0; l < LANES; l++)
                model[l][d[9:6]] = calc(op, dt, acc, model[l][a[9:6]], model[l][b[9:6]],
                                        model[l][d[9:6]]);
    endfunction

    task automatic drive_instr(logic op, logic [1:0] dt, logic acc,
                               logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] d);
        instr_valid = 1; instr_op = op; instr_dtype = dt; instr_acc = acc;
        instr_src_a = a; instr_src_b = b; instr_dst = d;
    endtask

    // Issue one instruction and check the busy window (R10) and the error flag (R12).
    task automatic issue(string tag, logic op, logic [1:0] dt, logic acc,
                         logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] d, logic exp_err);
        @(negedge clk);
        drive_instr(op, dt, acc, a, b, d);
        @(negedge clk);
        instr_valid = 0;
        chk1({tag, " R10 busy c1"}, busy, 1'b1);
        chk1({tag, " R12 err_flag"}, err_flag, exp_err);
        @(negedge clk);
        chk1({tag, " R10 busy c2"}, busy, 1'b1);
        @(negedge clk);
        chk1({tag, " R10 busy c3"}, busy, 1'b0 | 1'b1);
        @(negedge clk);
        chk1({tag, " R10 busy end"}, busy, 1'b0);
        apply_model(op, dt, acc, a, b, d);
    endtask

    task automatic t_reset();
        rst_n = 0; instr_valid = 0; instr_op = 0; instr_dtype = 0; instr_acc = 0;
        instr_src_a = 0; instr_src_b = 0; instr_dst = 0;
        ls_en = 0; ls_we = 0; ls_lane = 0; ls_word = 0; ls_wdata = '0;
        repeat (3) @(negedge clk);
        chk1("R1 busy", busy, 1'b0);
        chk1("R1 err_flag", err_flag, 1'b0);
        chk1("R1 rvalid", ls_rvalid, 1'b0);
        rst_n = 1;
        @(negedge clk);
        chk1("R1 busy after release", busy, 1'b0);
        chk1("R1 rvalid after release", ls_rvalid, 1'b0);
    endtask

    task automatic t_fill();
        for (int l = 0; l < LANES; l++)
            for (int w = 0; w < WORDS; w++) ls_write(l, w, rnd_word());
        for (int l = 0; l < LANES; l++) begin
            verify("R2 readback w0", l, 0);
            verify("R2 readback w13", l, 13);
        end
        ls_write(2, 7, {16{32'hCAFE_0000}});
        verify("R2 target lane", 2, 7);
        verify("R2 other lane untouched", 1, 7);
        verify("R2 other lane untouched", 3, 7);
    endtask

    task automatic t_int8();
        logic [WB-1:0] w1 = rnd_word();
        w1[7:0] = 8'h80; w1[15:8] = 8'h7F;
        ls_write(0, 1, w1);
        ls_write(0, 2, {{63{8'h03}}, 8'h80});
        issue("R5 int8 mul", 1'b0, 2'b00, 1'b0, 11'd64, 11'd128, 11'd576, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R3 R4 R5 int8 dst word9", l, 9);
        issue("R8 int8 add", 1'b1, 2'b00, 1'b0, 11'd192, 11'd256, 11'd320, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R8 int8 add dst word5", l, 5);
    endtask

    task automatic t_int16();
        issue("R6 int16 mul acc", 1'b0, 2'b01, 1'b1, 11'd0, 11'd448, 11'd704, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R6 R9 int16 acc word11", l, 11);
        issue("R9 int16 mul no acc", 1'b0, 2'b01, 1'b0, 11'd0, 11'd448, 11'd768, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R9 int16 no acc word12", l, 12);
    endtask

    task automatic t_int32();
        ls_write(1, 6, {16{32'h7000_0000}});
        ls_write(1, 8, {16{32'h9000_0000}});
        issue("R7 int32 add acc", 1'b1, 2'b10, 1'b1, 11'd384, 11'd384, 11'd512, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R7 R8 R9 int32 word8", l, 8);
        issue("R7 int32 mul", 1'b0, 2'b10, 1'b0, 11'd832, 11'd896, 11'd960, 1'b0);
        for (int l = 0; l < LANES; l++) verify("R7 int32 mul word15", l, 15);
    endtask

    task automatic t_port_busy();
        logic [WB-1:0] junk = rnd_word();
        @(negedge clk);
        drive_instr(1'b1, 2'b00, 1'b0, 11'd0, 11'd64, 11'd640);
        @(negedge clk);
        instr_valid = 0;
        ls_en = 1; ls_we = 1; ls_lane = 2'd1; ls_word = 4'd14; ls_wdata = junk;
        @(negedge clk);
        ls_we = 0;
        chk1("R11 no rvalid after busy write", ls_rvalid, 1'b0);
        @(negedge clk);
        chk1("R11 no rvalid for busy read", ls_rvalid, 1'b0);
        ls_en = 0;
        @(negedge clk);
        chk1("R11 R10 busy end", busy, 1'b0);
        apply_model(1'b1, 2'b00, 1'b0, 11'd0, 11'd64, 11'd640);
        verify("R11 busy write ignored", 1, 14);
        for (int l = 0; l < LANES; l++) verify("R11 instr result word10", l, 10);
    endtask

    task automatic t_instr_busy();
        @(negedge clk);
        drive_instr(1'b0, 2'b00, 1'b1, 11'd64, 11'd128, 11'd192);
        @(negedge clk);
        drive_instr(1'b1, 2'b01, 1'b0, 11'd0, 11'd0, 11'd896);
        chk1("R13 busy c1", busy, 1'b1);
        @(negedge clk);
        chk1("R13 busy c2", busy, 1'b1);
        @(negedge clk);
        instr_valid = 0;
        chk1("R13 busy c3", busy, 1'b1);
        @(negedge clk);
        chk1("R13 not restarted", busy, 1'b0);
        apply_model(1'b0, 2'b00, 1'b1, 11'd64, 11'd128, 11'd192);
        for (int l = 0; l < LANES; l++) begin
            verify("R13 first instr word3", l, 3);
            verify("R13 ignored instr word14", l, 14);
        end
    endtask

    task automatic t_errors();
        issue("R12 misaligned dst", 1'b0, 2'b00, 1'b0, 11'd64, 11'd128, 11'd580, 1'b1);
        for (int l = 0; l < LANES; l++) verify("R12 misaligned no write word9", l, 9);
        issue("R12 valid after err", 1'b1, 2'b01, 1'b0, 11'd64, 11'd128, 11'd256, 1'b1);
        for (int l = 0; l < LANES; l++) verify("R12 later instr runs word4", l, 4);
        issue("R12 out of range dst", 1'b0, 2'b00, 1'b0, 11'd64, 11'd128, 11'h400 | 11'd192, 1'b1);
        for (int l = 0; l < LANES; l++) verify("R12 range no write word3", l, 3);
        issue("R12 out of range src", 1'b0, 2'b00, 1'b0, 11'h440, 11'd128, 11'd128, 1'b1);
        for (int l = 0; l < LANES; l++) verify("R12 src range no write word2", l, 2);
        issue("R12 reserved dtype", 1'b0, 2'b11, 1'b0, 11'd64, 11'd128, 11'd256, 1'b1);
        for (int l = 0; l < LANES; l++) verify("R12 dtype no write word4", l, 4);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_int8();
        t_int16();
        t_int32();
        t_port_busy();
        t_instr_busy();
        t_errors();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule